// File: doc/BRIEF.md
# Modem Line Status Register with Change Flags

This block is one byte-wide, read-only status register for the four modem handshake inputs of a serial port: clear-to-send, data-set-ready, ring indicate and carrier detect. All four input pins are active low. Each pin passes through a two-stage synchronizer. The upper nibble of the register reports the active-high level of each line. The lower nibble holds sticky change flags. Any flag that is set raises an interrupt request. Flags clear when the host reads the register.

A loopback mode lets a port test itself. In this mode the four levels come from the port's own modem control outputs instead of the pins. Change detection follows whichever source is selected. The register sits at one address of a simple register port. A write to that address changes none of its bits and is passed out as a write strobe for a neighbouring register.

Top module: `mdm_status_reg`

## Requirements
- R1: In normal mode, bit 4 is CTS, bit 5 is DSR, bit 6 is RI and bit 7 is CD. Each is the complement of its synchronized pin. A pin change shows in these bits two clocks after it is applied.
- R2: When `loop_en` is 1, the level bits are mapped from `ctl_out` as follows: bit 4 = `ctl_out[1]`, bit 5 = `ctl_out[0]`, bit 6 = `ctl_out[2]`, bit 7 = `ctl_out[3]`.
- R3: The change flags are bit 0 (CTS), bit 1 (DSR) and bit 3 (CD). Each is set when its level bit changes in either direction, one clock after the level bit changes. It stays set until it is cleared by a read.
- R4: Bit 2 (RI change) is set only when the RI level bit goes from 1 to 0, which is a low-to-high transition of the pin. An RI level going from 0 to 1 leaves bit 2 unchanged.
- R5: A read is a cycle with `rd_stb`=1 and `addr`=REG_ADDR. During that cycle, `rd_data` returns the register value as it was before the clear. At the next clock edge, all four change flags clear. A read of any other address returns 0 and clears nothing.
- R6: `irq` is 1 exactly when any of bits 3:0 is 1.
- R7: A write to REG_ADDR pulses `alt_wr_stb` in the same cycle and leaves all bits unchanged. A write to any other address leaves `alt_wr_stb` at 0.
- R8: If a change event occurs on the same clock edge as a clearing read, the flag for that event is set after the edge.
- R9: Switching `loop_en` counts as a change for every line whose selected level differs between the two sources.
- R10: After reset, with all pins inactive (high), the register reads 0x00 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicate pin, active low |
| cd_n | input | 1 | Carrier detect pin, active low |
| loop_en | input | 1 | Loopback select |
| ctl_out | input | 4 | Modem control outputs: [0] DTR, [1] RTS, [2] aux 1, [3] aux 2 |
| addr | input | ADDR_W | Register address |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| rd_data | output | 8 | Read data; 0 unless this register is read |
| irq | output | 1 | Modem status interrupt request |
| alt_wr_stb | output | 1 | Write strobe forwarded to the register sharing this address |

## Verification
The assertions assume that `ctl_out` and `loop_en` are synchronous to `clk`, because they bypass the synchronizer. They also assume that `rd_stb` and `wr_stb` are single-cycle qualified strobes. The bench drives every input on the falling edge, so both assumptions hold. It holds each pin level for several clocks so that the synchronizer sees each transition. It places the one deliberate read-and-event collision on the loopback path, where the clock edge of the event is known exactly.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int NSIG    = 4;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_CD  = 3;
  // positions inside the modem control output vector
  localparam int CTL_DTR = 0;
  localparam int CTL_RTS = 1;
  localparam int CTL_AX1 = 2;
  localparam int CTL_AX2 = 3;
  typedef logic [NSIG-1:0] sig_vec_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d_in;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/mdm_src_sel.sv
module mdm_src_sel
  import mdm_pkg::*;
(
  input  sig_vec_t   pin_sync_n,
  input  logic [3:0] ctl_out,
  input  logic       loop_en,
  output sig_vec_t   level
);
  sig_vec_t loop_lvl;

  always_comb begin
    loop_lvl          = '0;
    loop_lvl[IDX_CTS] = ctl_out[CTL_RTS];
    loop_lvl[IDX_DSR] = ctl_out[CTL_DTR];
    loop_lvl[IDX_RI]  = ctl_out[CTL_AX1];
    loop_lvl[IDX_CD]  = ctl_out[CTL_AX2];
  end

  assign level = loop_en ? loop_lvl : ~pin_sync_n;
endmodule

// File: rtl/mdm_chg_detect.sv
module mdm_chg_detect
  import mdm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  sig_vec_t level,
  input  logic     clr,
  output sig_vec_t flags,
  output sig_vec_t evt
);
  sig_vec_t prev_q, flags_q, flags_d;

  genvar i;
  generate
    for (i = 0; i < NSIG; i++) begin : g_evt
      if (i == IDX_RI) begin : g_ri
        // pin low-to-high means active-high level falling
        assign evt[i] = prev_q[i] & ~level[i];
      end else begin : g_any
        assign evt[i] = prev_q[i] ^ level[i];
      end
    end
  endgenerate

  always_comb begin
    flags_d = clr ? '0 : flags_q;
    flags_d = flags_d | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      flags_q <= '0;
    end else begin
      prev_q  <= level;
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/mdm_status_reg.sv
module mdm_status_reg
  import mdm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] REG_ADDR = 3'd6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              cd_n,
  input  logic              loop_en,
  input  logic [3:0]        ctl_out,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  output logic [7:0]        rd_data,
  output logic              irq,
  output logic              alt_wr_stb
);
  sig_vec_t pin_raw_n, pin_sync_n, level, flags, evt;
  logic     hit, rd_hit;

  always_comb begin
    pin_raw_n          = '1;
    pin_raw_n[IDX_CTS] = cts_n;
    pin_raw_n[IDX_DSR] = dsr_n;
    pin_raw_n[IDX_RI]  = ri_n;
    pin_raw_n[IDX_CD]  = cd_n;
  end

  mdm_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pin_raw_n), .d_out(pin_sync_n)
  );

  mdm_src_sel u_sel (
    .pin_sync_n(pin_sync_n), .ctl_out(ctl_out), .loop_en(loop_en), .level(level)
  );

  mdm_chg_detect u_det (
    .clk(clk), .rst_n(rst_n), .level(level), .clr(rd_hit),
    .flags(flags), .evt(evt)
  );

  assign hit        = (addr == REG_ADDR);
  assign rd_hit     = rd_stb & hit;
  assign alt_wr_stb = wr_stb & hit;
  assign rd_data    = rd_hit ? {level, flags} : 8'h00;
  assign irq        = |flags;
endmodule

// File: rtl/mdm_status_chk.sv
module mdm_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_hit,
  input logic       loop_en,
  input logic [3:0] ctl_out,
  input logic [3:0] level,
  input logic [3:0] flags,
  input logic [3:0] evt,
  input logic [7:0] rd_data,
  input logic       irq
);
  AST_LOOP_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && loop_en) |-> rd_data[7:4] == {ctl_out[3], ctl_out[2], ctl_out[0], ctl_out[1]}); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> ((flags & $past(flags)) == $past(flags))); // R3

  AST_RI_RISE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(level[2]) && !flags[2] && !rd_hit) |=> !flags[2]); // R4

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && evt == 4'b0) |=> (flags == 4'b0 && !irq)); // R5

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && evt != 4'b0) |=> ((flags & $past(evt)) == $past(evt))); // R8

  AST_IRQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && rd_data[3:0] != 4'b0) |-> irq); // R6
endmodule

bind mdm_status_reg mdm_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .loop_en(loop_en),
  .ctl_out(ctl_out), .level(level), .flags(flags), .evt(evt),
  .rd_data(rd_data), .irq(irq)
);

// File: tb/mdm_status_reg_bench.sv
module mdm_status_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] RADDR = 3'd6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cts_n, dsr_n, ri_n, cd_n, loop_en;
  logic [3:0] ctl_out;
  logic [2:0] addr;
  logic       rd_stb, wr_stb;
  logic [7:0] rd_data;
  logic       irq, alt_wr_stb;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdm_status_reg u_mdm_status_reg (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
    .cd_n(cd_n), .loop_en(loop_en), .ctl_out(ctl_out), .addr(addr),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .rd_data(rd_data), .irq(irq),
    .alt_wr_stb(alt_wr_stb)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  // one read cycle at REG_ADDR, checked against exp
  task automatic rd_check(input string req, input logic [7:0] exp);
    @(negedge clk);
    addr = RADDR; rd_stb = 1'b1;
    #1 check(req, rd_data, exp);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 irq", {7'b0, irq}, 8'h00);
    rd_check("R10 reset value", 8'h00);
  endtask

  task automatic t_cts();
    @(negedge clk); cts_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 level after two clocks", {7'b0, irq}, 8'h00);
    settle();
    check("R6 irq set", {7'b0, irq}, 8'h01);
    rd_check("R1 R3 cts asserted", 8'h11);
    check("R6 irq cleared", {7'b0, irq}, 8'h00);
    rd_check("R5 flags cleared", 8'h10);
    @(negedge clk); cts_n = 1'b1; settle();
    rd_check("R3 cts release", 8'h01);
  endtask

  task automatic t_dsr_cd();
    @(negedge clk); dsr_n = 1'b0; cd_n = 1'b0; settle();
    rd_check("R1 R3 dsr cd assert", 8'hAA);
    @(negedge clk); dsr_n = 1'b1; settle();
    rd_check("R3 dsr release", 8'h82);
    @(negedge clk); cd_n = 1'b1; settle();
    rd_check("R3 cd release", 8'h08);
  endtask

  task automatic t_ri();
    @(negedge clk); ri_n = 1'b0; settle();
    check("R4 no irq on pin fall", {7'b0, irq}, 8'h00);
    rd_check("R4 ri pin fall no flag", 8'h40);
    @(negedge clk); ri_n = 1'b1; settle();
    rd_check("R4 ri pin rise flag", 8'h04);
  endtask

  task automatic t_write_other();
    @(negedge clk); cts_n = 1'b0; settle();
    @(negedge clk); addr = RADDR; wr_stb = 1'b1;
    #1 check("R7 alt strobe", {7'b0, alt_wr_stb}, 8'h01);
    @(negedge clk); addr = 3'd2;
    #1 check("R7 other addr no strobe", {7'b0, alt_wr_stb}, 8'h00);
    @(negedge clk); wr_stb = 1'b0; addr = 3'd2; rd_stb = 1'b1;
    #1 check("R5 other addr reads zero", rd_data, 8'h00);
    @(negedge clk); rd_stb = 1'b0;
    rd_check("R7 write left flags", 8'h11);
    @(negedge clk); cts_n = 1'b1; settle();
    rd_check("R3 cleanup", 8'h01);
  endtask

  task automatic t_loop();
    @(negedge clk); ctl_out = 4'b0001; loop_en = 1'b1; settle();
    rd_check("R2 R9 enter loop dtr", 8'h22);
    @(negedge clk); ctl_out = 4'b1010; settle();
    rd_check("R2 rts op2", 8'h9B);
    @(negedge clk); ctl_out = 4'b0100; settle();
    rd_check("R2 R4 aux1 rise", 8'h49);
    @(negedge clk); ctl_out = 4'b0000; settle();
    rd_check("R4 loop ri fall", 8'h04);
    // collision: event and clearing read on the same edge
    @(negedge clk); ctl_out = 4'b0010; addr = RADDR; rd_stb = 1'b1;
    #1 check("R5 pre-clear value", rd_data, 8'h10);
    @(negedge clk); rd_stb = 1'b0;
    rd_check("R8 event kept", 8'h11);
    @(negedge clk); loop_en = 1'b0; settle();
    rd_check("R9 leave loop", 8'h01);
    @(negedge clk); ctl_out = 4'b0000; settle();
    rd_check("R9 ctl ignored outside loop", 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; cts_n = 1'b1; dsr_n = 1'b1; ri_n = 1'b1; cd_n = 1'b1;
    loop_en = 1'b0; ctl_out = 4'b0; addr = 3'd0; rd_stb = 1'b0; wr_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cts();
    t_dsr_cd();
    t_ri();
    t_write_other();
    t_loop();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule